// File: doc/BRIEF.md
# Multi-Bin Hit Time Binner

This block turns the discriminator levels of one drift cell's wires into a compact time picture of a single bunch crossing. A crossing-start strobe opens a window of programmable length counted in sample-clock periods. The window is split into six time bins whose start positions are programmable and need not be evenly spaced. Each wire gets one flag per bin, and a flag is set when the wire is seen high in any sample that falls inside that bin. With twelve wires this gives a 72-bit word per crossing.

Discriminator pulses are typically longer than a bin, so a single pulse tends to light two neighbouring bins. To keep that tail out of the word, each bin after the first has a programmable guard interval at its start. A high sample inside the guard is dropped when the same wire already holds a flag in the bin just before. Bin 0 has no guard. When the last sample of the window has been taken, the word is latched onto the output and held there until the next window ends, and a one-cycle valid pulse marks the update. The bin edges, guard lengths and window length are captured from the configuration inputs on the strobe cycle.

Top module: `hit_time_binner`

## Requirements
- R1: After reset `hit_word` is all zeros and `hit_word_valid` is low.
- R2: The flag for wire w and bin b sits at bit w*NUM_BINS+b of `hit_word`. The sample taken on the clock edge where `xing_start` is seen high is position 0. With window length L, `hit_word_valid` is high for exactly one cycle, following the L-th rising edge after that strobe edge, and `hit_word` carries the new word from that cycle on.
- R3: Bin edges come in `cfg_bin_edge` as NUM_BINS-1 fields of CNT_W bits. Field k-1 holds the start position of bin k, and the fields must be non-decreasing. Bin 0 starts at position 0. A sample at position p belongs to the highest bin k whose start is at or below p.
- R4: For a bin k of 1 or more, a high sample at a position below start(k)+guard(k) is ignored when the same wire's flag for bin k-1 is already set in this window. The guard lengths come from `cfg_guard_len`, laid out in the same field order as the edges.
- R5: A high sample inside a guard interval sets the flag when the wire's previous bin flag is clear.
- R6: Bin 0 applies no guard. A high sample at any position in bin 0, including position 0, sets the flag.
- R7: Samples taken before the strobe, or at positions L and above, set no flags.
- R8: Between valid pulses `hit_word` does not change, whatever the wires do.
- R9: A strobe that arrives before the window has ended restarts it at position 0. The unfinished window produces no valid pulse and leaves nothing in the next word.
- R10: The configuration is taken on the strobe cycle. Changes to the configuration inputs during a window have no effect on that window.
- R11: Each wire's flags depend only on that wire's samples.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xing_start | input | 1 | Crossing-start strobe; opens a new window |
| wire_lvl | input | NUM_WIRES | Discriminator level for each wire |
| cfg_bin_edge | input | (NUM_BINS-1)*CNT_W | Start positions of bins 1 and up |
| cfg_guard_len | input | (NUM_BINS-1)*CNT_W | Guard length for bins 1 and up |
| cfg_win_len | input | CNT_W | Window length in samples (1 or more) |
| hit_word | output | NUM_WIRES*NUM_BINS | Latched bin flags of the last finished window |
| hit_word_valid | output | 1 | One-cycle pulse when hit_word is updated |

## Verification
The bench uses the default sizes: twelve wires, six bins and an eight-bit position counter. At that size the full 72-bit word is checked bit for bit against a model in the bench. Windows of 8 to 30 samples keep each scenario short. This still allows an evenly spaced layout, an uneven layout with a two-sample bin and a one-sample bin, and per-bin guard lengths. Long and short pulses are placed to land inside, across and beyond the guard intervals. The bench also covers an aborted eight-sample window whose old end falls inside the window that replaces it.

// File: rtl/hit_binner_pkg.sv
package hit_binner_pkg;

    localparam int DEF_WIRES = 12;
    localparam int DEF_BINS  = 6;
    localparam int DEF_CNT_W = 8;

    // Position of a wire/bin flag inside the packed output word
    function automatic int flag_index(input int wire_idx, input int bin_idx, input int nbins);
        return wire_idx * nbins + bin_idx;
    endfunction

endpackage

// File: rtl/hit_window_timer.sv
module hit_window_timer #(
    parameter int CNT_W = hit_binner_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic [CNT_W-1:0] win_len,
    output logic [CNT_W-1:0] pos,
    output logic             active,
    output logic             last
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             act;
    } tmr_state_t;

    tmr_state_t st_d, st_q;
    logic [CNT_W:0] next_pos;

    always_comb begin
        st_d     = st_q;
        next_pos = {1'b0, st_q.cnt} + {{CNT_W{1'b0}}, 1'b1};
        last     = st_q.act && (next_pos == {1'b0, win_len});
        if (restart) begin
            st_d.cnt = '0;
            st_d.act = 1'b1;
        end else if (last) begin
            st_d.act = 1'b0;
        end else if (st_q.act) begin
            st_d.cnt = next_pos[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pos    = st_q.cnt;
    assign active = st_q.act;

endmodule

// File: rtl/bin_locator.sv
module bin_locator #(
    parameter int NUM_BINS = hit_binner_pkg::DEF_BINS,
    parameter int CNT_W    = hit_binner_pkg::DEF_CNT_W,
    localparam int EDGE_W  = (NUM_BINS - 1) * CNT_W
) (
    input  logic [CNT_W-1:0]    pos,
    input  logic [EDGE_W-1:0]   edges,
    input  logic [EDGE_W-1:0]   guards,
    output logic [NUM_BINS-1:0] sel,
    output logic                in_guard
);

    logic [NUM_BINS-1:0] reached;
    logic [NUM_BINS-1:0] guard_hit;

    assign reached[0]   = 1'b1;
    assign guard_hit[0] = 1'b0;

    generate
        for (genvar k = 1; k < NUM_BINS; k++) begin : g_edge
            logic [CNT_W-1:0] start_k;
            logic [CNT_W:0]   guard_end_k;
            always_comb begin
                start_k      = edges[(k-1)*CNT_W +: CNT_W];
                guard_end_k  = {1'b0, start_k} + {1'b0, guards[(k-1)*CNT_W +: CNT_W]};
                reached[k]   = (pos >= start_k);
                guard_hit[k] = ({1'b0, pos} < guard_end_k);
            end
        end
        for (genvar k = 0; k < NUM_BINS - 1; k++) begin : g_sel
            assign sel[k] = reached[k] & ~reached[k+1];
        end
    endgenerate

    assign sel[NUM_BINS-1] = reached[NUM_BINS-1];
    assign in_guard        = |(sel & guard_hit);

endmodule

// File: rtl/wire_bin_accum.sv
module wire_bin_accum #(
    parameter int NUM_BINS = hit_binner_pkg::DEF_BINS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                clear,
    input  logic                sample_en,
    input  logic                wire_smp,
    input  logic [NUM_BINS-1:0] sel,
    input  logic                in_guard,
    output logic [NUM_BINS-1:0] flags_upd
);

    logic [NUM_BINS-1:0] flags_d, flags_q;
    logic [NUM_BINS-1:0] prev_flags;
    logic                prev_set;
    logic                take;

    always_comb begin
        prev_flags = {flags_q[NUM_BINS-2:0], 1'b0};
        prev_set   = |(sel & prev_flags);
        take       = sample_en && wire_smp && !(in_guard && prev_set);
        flags_upd  = flags_q | (sel & {NUM_BINS{take}});
        flags_d    = clear ? '0 : flags_upd;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flags_q <= '0;
        end else begin
            flags_q <= flags_d;
        end
    end

endmodule

// File: rtl/hit_time_binner.sv
module hit_time_binner #(
    parameter int NUM_WIRES = hit_binner_pkg::DEF_WIRES,
    parameter int NUM_BINS  = hit_binner_pkg::DEF_BINS,
    parameter int CNT_W     = hit_binner_pkg::DEF_CNT_W,
    localparam int EDGE_W   = (NUM_BINS - 1) * CNT_W,
    localparam int WORD_W   = NUM_WIRES * NUM_BINS
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 xing_start,
    input  logic [NUM_WIRES-1:0] wire_lvl,
    input  logic [EDGE_W-1:0]    cfg_bin_edge,
    input  logic [EDGE_W-1:0]    cfg_guard_len,
    input  logic [CNT_W-1:0]     cfg_win_len,
    output logic [WORD_W-1:0]    hit_word,
    output logic                 hit_word_valid
);

    typedef struct packed {
        logic [NUM_WIRES-1:0] wire_smp;
        logic [EDGE_W-1:0]    edges;
        logic [EDGE_W-1:0]    guards;
        logic [CNT_W-1:0]     win_len;
        logic [WORD_W-1:0]    word;
        logic                 valid;
    } top_state_t;

    top_state_t st_d, st_q;

    logic [CNT_W-1:0]    pos;
    logic                active;
    logic                last;
    logic [NUM_BINS-1:0] sel;
    logic                in_guard;
    logic [WORD_W-1:0]   upd_word;

    hit_window_timer #(.CNT_W(CNT_W)) timer_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .restart (xing_start),
        .win_len (st_q.win_len),
        .pos     (pos),
        .active  (active),
        .last    (last)
    );

    bin_locator #(.NUM_BINS(NUM_BINS), .CNT_W(CNT_W)) locator_i (
        .pos      (pos),
        .edges    (st_q.edges),
        .guards   (st_q.guards),
        .sel      (sel),
        .in_guard (in_guard)
    );

    generate
        for (genvar w = 0; w < NUM_WIRES; w++) begin : g_wire
            localparam int BASE = hit_binner_pkg::flag_index(w, 0, NUM_BINS);
            wire_bin_accum #(.NUM_BINS(NUM_BINS)) accum_i (
                .clk       (clk),
                .rst_n     (rst_n),
                .clear     (xing_start | last),
                .sample_en (active),
                .wire_smp  (st_q.wire_smp[w]),
                .sel       (sel),
                .in_guard  (in_guard),
                .flags_upd (upd_word[BASE +: NUM_BINS])
            );
        end
    endgenerate

    always_comb begin
        st_d          = st_q;
        st_d.wire_smp = wire_lvl;
        st_d.valid    = last;
        if (xing_start) begin
            st_d.edges   = cfg_bin_edge;
            st_d.guards  = cfg_guard_len;
            st_d.win_len = cfg_win_len;
        end
        if (last) begin
            st_d.word = upd_word;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit_word       = st_q.word;
    assign hit_word_valid = st_q.valid;

endmodule

// File: rtl/hit_time_binner_chk.sv
module hit_time_binner_chk #(
    parameter int NUM_BINS = 6,
    parameter int CNT_W    = 8,
    parameter int WORD_W   = 72
) (
    input logic                clk,
    input logic                rst_n,
    input logic                xing_start,
    input logic                active,
    input logic [CNT_W-1:0]    pos,
    input logic [NUM_BINS-1:0] sel,
    input logic                in_guard,
    input logic [WORD_W-1:0]   hit_word,
    input logic                hit_word_valid
);

    // R9: a strobe always restarts the window at position 0
    assert_restart_R9: assert property (@(posedge clk) disable iff (!rst_n)
        xing_start |=> (active && pos == '0));

    // R3: every in-window sample lands in exactly one bin
    assert_one_bin_R3: assert property (@(posedge clk) disable iff (!rst_n)
        active |-> ($countones(sel) == 1));

    // R6: the first bin never reports a guard interval
    assert_no_guard_bin0_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (active && sel[0]) |-> !in_guard);

    // R8: the output only moves together with the valid pulse
    assert_hold_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !hit_word_valid |-> $stable(hit_word));

    // R2: a valid pulse only follows a sampling cycle of an open window
    assert_pulse_from_window_R2: assert property (@(posedge clk) disable iff (!rst_n)
        hit_word_valid |-> $past(active));

    // R7: a closed window stays closed until the next strobe
    assert_stay_closed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!active && !xing_start) |=> !active);

endmodule

bind hit_time_binner hit_time_binner_chk #(
    .NUM_BINS (NUM_BINS),
    .CNT_W    (CNT_W),
    .WORD_W   (WORD_W)
) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .xing_start     (xing_start),
    .active         (active),
    .pos            (pos),
    .sel            (sel),
    .in_guard       (in_guard),
    .hit_word       (hit_word),
    .hit_word_valid (hit_word_valid)
);

// File: tb/hit_time_binner_tb_top.sv
module hit_time_binner_tb_top;

    localparam int NW = 12;
    localparam int NB = 6;
    localparam int CW = 8;
    localparam int WW = NW * NB;
    localparam int EW = (NB - 1) * CW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          xing_start = 1'b0;
    logic [NW-1:0] wire_lvl = '0;
    logic [EW-1:0] cfg_bin_edge = '0;
    logic [EW-1:0] cfg_guard_len = '0;
    logic [CW-1:0] cfg_win_len = '0;
    logic [WW-1:0] hit_word;
    logic          hit_word_valid;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    logic [NW-1:0] stim [0:63];
    int edge_m  [1:NB-1];
    int guard_m [1:NB-1];
    int len_m;

    always #10 clk = ~clk;

    hit_time_binner dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .xing_start     (xing_start),
        .wire_lvl       (wire_lvl),
        .cfg_bin_edge   (cfg_bin_edge),
        .cfg_guard_len  (cfg_guard_len),
        .cfg_win_len    (cfg_win_len),
        .hit_word       (hit_word),
        .hit_word_valid (hit_word_valid)
    );

    task automatic chk(input bit ok, input string req, input logic [WW-1:0] act, input logic [WW-1:0] exp);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic clear_stim();
        for (int p = 0; p < 64; p++) stim[p] = '0;
    endtask

    task automatic drive_cfg();
        for (int k = 1; k < NB; k++) begin
            cfg_bin_edge[(k-1)*CW +: CW]  = CW'(edge_m[k]);
            cfg_guard_len[(k-1)*CW +: CW] = CW'(guard_m[k]);
        end
        cfg_win_len = CW'(len_m);
    endtask

    task automatic set_cfg(input int e1, e2, e3, e4, e5, g1, g2, g3, g4, g5, L);
        edge_m[1] = e1; edge_m[2] = e2; edge_m[3] = e3; edge_m[4] = e4; edge_m[5] = e5;
        guard_m[1] = g1; guard_m[2] = g2; guard_m[3] = g3; guard_m[4] = g4; guard_m[5] = g5;
        len_m = L;
        drive_cfg();
    endtask

    function automatic logic [WW-1:0] model();
        logic [WW-1:0] res = '0;
        for (int w = 0; w < NW; w++) begin
            logic [NB-1:0] f = '0;
            for (int p = 0; p < len_m; p++) begin
                if (stim[p][w]) begin
                    int k = 0;
                    bit g;
                    for (int j = 1; j < NB; j++) if (p >= edge_m[j]) k = j;
                    g = (k > 0) && (p < edge_m[k] + guard_m[k]);
                    if (!(g && f[k-1])) f[k] = 1'b1;
                end
            end
            res[w*NB +: NB] = f;
        end
        return res;
    endfunction

    // Drives one window from stim[0..len_m-1]; chg_at >= 0 scrambles the config inputs there
    task automatic run_window(input int chg_at, input string req);
        logic [WW-1:0] exp = model();
        bit early = 1'b0;
        for (int p = 0; p < len_m; p++) begin
            @(negedge clk);
            if (p > 0 && hit_word_valid) early = 1'b1;
            xing_start = (p == 0);
            wire_lvl   = stim[p];
            if (p == chg_at) begin
                cfg_bin_edge  = ~cfg_bin_edge;
                cfg_guard_len = '1;
                cfg_win_len   = 8'd3;
            end
        end
        @(negedge clk);
        if (hit_word_valid) early = 1'b1;
        xing_start = 1'b0;
        wire_lvl   = '1;              // beyond the window (R7)
        chk(!early, {req, " R2 no pulse before window end"}, {71'b0, early}, '0);
        @(negedge clk);
        chk(hit_word_valid === 1'b1, {req, " R2 valid pulse"}, {71'b0, hit_word_valid}, 72'd1);
        chk(hit_word === exp, {req, " word"}, hit_word, exp);
        wire_lvl = '1;
        @(negedge clk);
        chk(hit_word_valid === 1'b0, {req, " R2 single-cycle valid"}, {71'b0, hit_word_valid}, '0);
        wire_lvl = '0;
        drive_cfg();
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        chk(hit_word === '0, "R1 word after reset", hit_word, '0);
        chk(hit_word_valid === 1'b0, "R1 valid after reset", {71'b0, hit_word_valid}, '0);
    endtask

    task automatic t_uniform();
        set_cfg(4, 8, 12, 16, 20, 0, 0, 0, 0, 0, 24);
        clear_stim();
        stim[0]  = 12'h001;   // wire 0 bin 0
        stim[5]  = 12'h002;   // wire 1 bin 1
        stim[11] = 12'h800;   // wire 11 bin 2
        stim[12] = 12'h010;   // wire 4 bin 3 at its first sample
        stim[23] = 12'h400;   // wire 10 bin 5 last sample
        stim[17] = 12'h0A0;   // wires 5,7 bin 4
        run_window(-1, "R2 R3 R11 uniform");
        clear_stim();
        for (int p = 0; p < 24; p++) stim[p] = 12'h008;   // wire 3 always high
        stim[9] = 12'h108;
        run_window(-1, "R2 R11 solid wire");
    endtask

    task automatic t_guard();
        set_cfg(4, 8, 12, 16, 20, 3, 3, 3, 3, 3, 24);
        clear_stim();
        for (int p = 2; p <= 6; p++) stim[p][0] = 1'b1;   // tail fully in guard of bin 1 (R4)
        for (int p = 4; p <= 6; p++) stim[p][1] = 1'b1;   // guard hit, bin 0 empty (R5)
        stim[0][2] = 1'b1;                                // bin 0 position 0 (R6)
        stim[1][3] = 1'b1; stim[7][3] = 1'b1;             // past the guard counts
        for (int p = 10; p <= 14; p++) stim[p][4] = 1'b1; // R4 tail into bin 3 guard
        run_window(-1, "R4 R5 R6 guard");
        chk(hit_word[0*NB+1] === 1'b0, "R4 guarded tail", {71'b0, hit_word[1]}, '0);
        chk(hit_word[1*NB+1] === 1'b1, "R5 guard with empty previous", {71'b0, hit_word[7]}, 72'd1);
        chk(hit_word[2*NB+0] === 1'b1, "R6 bin 0 at position 0", {71'b0, hit_word[12]}, 72'd1);
    endtask

    task automatic t_nonuniform();
        set_cfg(3, 5, 9, 17, 18, 1, 2, 0, 4, 0, 30);
        clear_stim();
        stim[2][0] = 1'b1; stim[3][0] = 1'b1;              // bin 0, bin 1 guard
        stim[4][1] = 1'b1;                                 // bin 1 beyond guard
        stim[5][2] = 1'b1; stim[6][2] = 1'b1;              // bin 2
        stim[8][5] = 1'b1; stim[9][5] = 1'b1;              // bin 2 then bin 3 (no guard)
        stim[17][6] = 1'b1;                                // one-sample bin 4
        stim[16][7] = 1'b1; stim[17][7] = 1'b1; stim[18][7] = 1'b1;
        stim[29][9] = 1'b1;                                // last sample
        run_window(-1, "R3 R4 uneven edges");
        set_cfg(4, 4, 12, 16, 20, 2, 2, 2, 2, 2, 24);     // empty bin 1
        clear_stim();
        stim[4][0] = 1'b1; stim[3][1] = 1'b1;
        run_window(-1, "R3 empty bin");
        chk(hit_word[0*NB+1] === 1'b0 && hit_word[0*NB+2] === 1'b1, "R3 empty bin owns no sample",
            {70'b0, hit_word[2], hit_word[1]}, 72'd2);
    endtask

    task automatic t_outside();
        set_cfg(2, 4, 6, 8, 10, 1, 1, 1, 1, 1, 12);
        wire_lvl = '1;
        repeat (4) @(negedge clk);         // activity before the strobe
        clear_stim();
        stim[3] = 12'h020;
        run_window(-1, "R7 outside window");
        chk(hit_word === 72'(1) << (5*NB+1), "R7 only in-window sample", hit_word, 72'(1) << (5*NB+1));
    endtask

    task automatic t_hold();
        logic [WW-1:0] held = hit_word;
        bit bad = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            wire_lvl = NW'(i * 37);
            if (hit_word !== held || hit_word_valid !== 1'b0) bad = 1'b1;
        end
        wire_lvl = '0;
        chk(!bad, "R8 word held between pulses", hit_word, held);
    endtask

    task automatic t_abort();
        bit early = 1'b0;
        set_cfg(2, 3, 4, 5, 6, 0, 0, 0, 0, 0, 8);
        @(negedge clk);
        xing_start = 1'b1;
        wire_lvl   = '1;
        for (int p = 1; p < 6; p++) begin
            @(negedge clk);
            xing_start = 1'b0;
            wire_lvl   = '1;
            if (hit_word_valid) early = 1'b1;
        end
        chk(!early, "R9 no pulse from aborted window", {71'b0, early}, '0);
        clear_stim();
        stim[1][8] = 1'b1;
        run_window(-1, "R9 restarted window");
    endtask

    task automatic t_cfg_change();
        set_cfg(4, 8, 12, 16, 20, 2, 2, 2, 2, 2, 24);
        clear_stim();
        stim[7][0] = 1'b1; stim[8][0] = 1'b1; stim[9][0] = 1'b1;
        stim[20][3] = 1'b1; stim[23][11] = 1'b1;
        run_window(2, "R10 config change mid-window");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_uniform();
        t_guard();
        t_nonuniform();
        t_outside();
        t_hold();
        t_abort();
        t_cfg_change();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: run did not complete actual=hung expected=finished");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

endmodule